// File: doc/BRIEF.md
# Frequency lock detector with acquisition control

This block watches a divided recovered clock and decides whether its rate matches a reference clock closely enough for a clock-and-data-recovery loop to switch from reference-based acquisition to data-based tracking. It counts recovered-clock edges with a Gray-coded counter. The count crosses into the reference domain, where the edges seen over a fixed window of `WIN_CYC` reference cycles give a measured count. The measured count is compared with the count the selected rate ratio should produce. Both ppm thresholds are converted into count thresholds when the block is elaborated, so no division happens while it runs.

Three registered outputs come from the absolute count error:
- `lol_no` is an active-low loss-of-lock flag. It has hysteresis between a tight lock threshold and a loose unlock threshold.
- `sync_err_o` flags any error outside the lock threshold.
- `pd_sel_o` chooses reference acquisition (1) or data tracking (0).

An active-low loss-of-signal input overrides the select toward reference acquisition. This holds the output clock frequency while the data is absent. Tying that input high turns the override off. `rate_sel_i` picks one of two reference ratios. With ratio 0 the recovered clock runs at the reference rate. With ratio 1 it runs `RATE_MULT` times faster.

Top module: `freq_lock_detect`

## Requirements
- R1: When the absolute error |measured - expected| of a window exceeds floor(expected * UNLOCK_PPM / 10^6) counts, `lol_no` is 0 (not locked) after that window.
- R2: `lol_no` becomes 1 only after a window whose error is at most floor(expected * LOCK_PPM / 10^6) counts. A window whose error lies strictly between the two thresholds leaves `lol_no` unchanged.
- R3: `sync_err_o` is 1 after a window whose error exceeds the lock threshold, and 0 after a window whose error is within it.
- R4: While `los_ni` is high, `pd_sel_o` equals `sync_err_o`. Value 1 selects reference acquisition and 0 selects data-based tracking.
- R5: While `los_ni` is low, `pd_sel_o` is 1 within three reference cycles, whatever the error. `lol_no` and `sync_err_o` keep following the measurement.
- R6: With `rate_sel_i` = 0 the expected count per window is `WIN_CYC`. With `rate_sel_i` = 1 it is `RATE_MULT * WIN_CYC`. Both thresholds scale with the expected count.
- R7: During reset and until the first evaluation, `lol_no` = 0, `sync_err_o` = 1 and `pd_sel_o` = 1. The first window after reset only primes the count. The first evaluation ends the second window.
- R8: Windows are `WIN_CYC` reference cycles long and start at reset release. `lol_no` and `sync_err_o` change only on reference edge N*`WIN_CYC`+1, counting the first rising edge after release as edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; all outputs are registered on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rec_clk_i | input | 1 | Divided recovered clock under measurement |
| rate_sel_i | input | 1 | Reference ratio: 0 = same rate as recovered, 1 = RATE_MULT times slower |
| los_ni | input | 1 | Active-low loss of signal; low forces reference acquisition |
| lol_no | output | 1 | Active-low loss of lock with hysteresis |
| sync_err_o | output | 1 | Error beyond the lock threshold |
| pd_sel_o | output | 1 | 1 = reference acquisition, 0 = data tracking |

## Verification
The bench builds the block with `WIN_CYC` = 10000, `RATE_MULT` = 4 and thresholds of 500 and 1000 ppm. One count is then 100 ppm at ratio 0 and 25 ppm at ratio 1. Offsets of 0, 400, 700 and 1200 ppm therefore land in distinct bands, with more than the one-count quantization of the Gray crossing to spare. With these values a single run can reach both ratios, the hysteresis hold from either side, and loss-of-signal holdover while `sync_err_o` changes underneath it.

// File: rtl/freq_lock_pkg.sv
`timescale 1ps/1fs
package freq_lock_pkg;
  typedef enum logic [1:0] {
    CAT_IN   = 2'd0,
    CAT_BAND = 2'd1,
    CAT_OUT  = 2'd2
  } err_cat_e;

  localparam int unsigned PPM_SCALE = 1_000_000;
endpackage

// File: rtl/freq_lock_rec_count.sv
`timescale 1ps/1fs
module freq_lock_rec_count #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             rec_clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] gray_o
);
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nxt;

  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge rec_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_o <= bin_nxt ^ (bin_nxt >> 1);
    end
  end
endmodule

// File: rtl/freq_lock_gray_sync.sv
`timescale 1ps/1fs
module freq_lock_gray_sync #(
  parameter int unsigned CNT_W  = 18,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] gray_i,
  output logic [CNT_W-1:0] bin_o
);
  logic [CNT_W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= gray_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  // gray to binary: bit i is the parity of gray bits i and above
  for (genvar i = 0; i < CNT_W; i++) begin : g_g2b
    assign bin_o[i] = ^(stg_q[STAGES-1] >> i);
  end
endmodule

// File: rtl/freq_lock_window.sv
`timescale 1ps/1fs
module freq_lock_window #(
  parameter int unsigned WIN_CYC = 10000,
  parameter int unsigned CNT_W   = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             meas_vld_o
);
  localparam int unsigned WC_W = $clog2(WIN_CYC);

  logic [WC_W-1:0]  wcnt_q;
  logic             primed_q;
  logic [CNT_W-1:0] prev_q;
  logic             win_end;

  assign win_end = (wcnt_q == WC_W'(WIN_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q     <= '0;
      primed_q   <= 1'b0;
      prev_q     <= '0;
      meas_o     <= '0;
      meas_vld_o <= 1'b0;
    end else begin
      meas_vld_o <= 1'b0;
      if (win_end) begin
        wcnt_q     <= '0;
        prev_q     <= cnt_i;
        meas_o     <= cnt_i - prev_q;
        meas_vld_o <= primed_q;  // first window only primes prev_q
        primed_q   <= 1'b1;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  // checker: spacing between results
  logic [WC_W:0] gap_q;
  logic          seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (meas_vld_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_window_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld_o && seen_q) |-> (gap_q == (WC_W+1)'(WIN_CYC - 1)));
endmodule

// File: rtl/freq_lock_ctrl.sv
`timescale 1ps/1fs
module freq_lock_ctrl
  import freq_lock_pkg::*;
#(
  parameter int unsigned CNT_W      = 18,
  parameter int unsigned WIN_CYC    = 10000,
  parameter int unsigned RATE_MULT  = 4,
  parameter int unsigned LOCK_PPM   = 500,
  parameter int unsigned UNLOCK_PPM = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             meas_vld_i,
  input  logic             rate_sel_i,
  input  logic             los_ni,
  output logic             lol_no,
  output logic             sync_err_o,
  output logic             pd_sel_o
);
  localparam logic [63:0] EXP_LO_L = 64'(WIN_CYC);
  localparam logic [63:0] EXP_HI_L = 64'(WIN_CYC) * 64'(RATE_MULT);
  localparam logic [63:0] TLK_LO_L = EXP_LO_L * 64'(LOCK_PPM)   / 64'(PPM_SCALE);
  localparam logic [63:0] TUL_LO_L = EXP_LO_L * 64'(UNLOCK_PPM) / 64'(PPM_SCALE);
  localparam logic [63:0] TLK_HI_L = EXP_HI_L * 64'(LOCK_PPM)   / 64'(PPM_SCALE);
  localparam logic [63:0] TUL_HI_L = EXP_HI_L * 64'(UNLOCK_PPM) / 64'(PPM_SCALE);

  localparam logic [CNT_W-1:0] EXP_LO = EXP_LO_L[CNT_W-1:0];
  localparam logic [CNT_W-1:0] EXP_HI = EXP_HI_L[CNT_W-1:0];
  localparam logic [CNT_W-1:0] TLK_LO = TLK_LO_L[CNT_W-1:0];
  localparam logic [CNT_W-1:0] TUL_LO = TUL_LO_L[CNT_W-1:0];
  localparam logic [CNT_W-1:0] TLK_HI = TLK_HI_L[CNT_W-1:0];
  localparam logic [CNT_W-1:0] TUL_HI = TUL_HI_L[CNT_W-1:0];

  logic [CNT_W-1:0] exp_cnt, th_lock, th_unlock, diff;
  err_cat_e         cat;
  logic [1:0]       los_sync_q;
  logic             los_ok;
  logic             lol_q, sync_q, sel_q;
  logic             lol_nxt, sync_nxt, sel_nxt;

  always_comb begin
    exp_cnt   = rate_sel_i ? EXP_HI : EXP_LO;
    th_lock   = rate_sel_i ? TLK_HI : TLK_LO;
    th_unlock = rate_sel_i ? TUL_HI : TUL_LO;
    diff      = (meas_i >= exp_cnt) ? (meas_i - exp_cnt) : (exp_cnt - meas_i);
    if (diff > th_unlock)     cat = CAT_OUT;
    else if (diff <= th_lock) cat = CAT_IN;
    else                      cat = CAT_BAND;
  end

  assign los_ok = los_sync_q[1];

  always_comb begin
    sync_nxt = sync_q;
    lol_nxt  = lol_q;
    if (meas_vld_i) begin
      sync_nxt = (cat != CAT_IN);
      if (cat == CAT_IN)       lol_nxt = 1'b1;
      else if (cat == CAT_OUT) lol_nxt = 1'b0;
    end
    sel_nxt = !los_ok || sync_nxt;  // holdover wins over the error
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      los_sync_q <= '0;
      lol_q      <= 1'b0;
      sync_q     <= 1'b1;
      sel_q      <= 1'b1;
    end else begin
      los_sync_q <= {los_sync_q[0], los_ni};
      lol_q      <= lol_nxt;
      sync_q     <= sync_nxt;
      sel_q      <= sel_nxt;
    end
  end

  assign lol_no     = lol_q;
  assign sync_err_o = sync_q;
  assign pd_sel_o   = sel_q;

  assert_lol_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lol_no) |-> sync_err_o);
  assert_lol_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lol_no) |-> !sync_err_o);
  assert_flags_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_vld_i |=> ($stable(sync_err_o) && $stable(lol_no)));
  assert_sel_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_ok |=> (pd_sel_o == sync_err_o));
  assert_holdover_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !los_ok |=> pd_sel_o);
endmodule

// File: rtl/freq_lock_detect.sv
`timescale 1ps/1fs
module freq_lock_detect #(
  parameter int unsigned WIN_CYC     = 10000,
  parameter int unsigned RATE_MULT   = 4,
  parameter int unsigned LOCK_PPM    = 500,
  parameter int unsigned UNLOCK_PPM  = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic rec_clk_i,
  input  logic rate_sel_i,
  input  logic los_ni,
  output logic lol_no,
  output logic sync_err_o,
  output logic pd_sel_o
);
  localparam int unsigned CNT_W = $clog2(WIN_CYC * RATE_MULT * 2) + 1;

  logic [CNT_W-1:0] rec_gray, rec_bin, meas;
  logic             meas_vld;

  freq_lock_rec_count #(.CNT_W(CNT_W)) u_rec (
    .rec_clk_i (rec_clk_i),
    .rst_ni    (rst_ni),
    .gray_o    (rec_gray)
  );

  freq_lock_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .gray_i (rec_gray),
    .bin_o  (rec_bin)
  );

  freq_lock_window #(.WIN_CYC(WIN_CYC), .CNT_W(CNT_W)) u_win (
    .clk_i      (ref_clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (rec_bin),
    .meas_o     (meas),
    .meas_vld_o (meas_vld)
  );

  freq_lock_ctrl #(
    .CNT_W      (CNT_W),
    .WIN_CYC    (WIN_CYC),
    .RATE_MULT  (RATE_MULT),
    .LOCK_PPM   (LOCK_PPM),
    .UNLOCK_PPM (UNLOCK_PPM)
  ) u_ctrl (
    .clk_i      (ref_clk_i),
    .rst_ni     (rst_ni),
    .meas_i     (meas),
    .meas_vld_i (meas_vld),
    .rate_sel_i (rate_sel_i),
    .los_ni     (los_ni),
    .lol_no     (lol_no),
    .sync_err_o (sync_err_o),
    .pd_sel_o   (pd_sel_o)
  );
endmodule

// File: tb/sim_freq_lock_detect.sv
`timescale 1ps/1fs
module sim_freq_lock_detect;
  localparam int W = 10000;

  logic ref_clk = 1'b0;
  logic rec_clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_sel = 1'b0;
  logic los_n = 1'b1;
  logic lol_n, sync_err, pd_sel;

  int ppm = 0;
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  // reference model state
  logic  exp_lol = 1'b0, exp_sync = 1'b1;
  bit    lol_kn = 1'b1, sync_kn = 1'b1, evaluated = 1'b0;
  int    mid_ppm = 0, mid_rate = 0, prev_rate = 0, los_guard = 0;
  string lol_tag = "R7", sync_tag = "R7";
  logic  lol_prev = 1'b0, sync_prev = 1'b1;

  freq_lock_detect #(
    .WIN_CYC(W), .RATE_MULT(4), .LOCK_PPM(500), .UNLOCK_PPM(1000), .SYNC_STAGES(2)
  ) u0 (
    .ref_clk_i  (ref_clk),
    .rst_ni     (rst_n),
    .rec_clk_i  (rec_clk),
    .rate_sel_i (rate_sel),
    .los_ni     (los_n),
    .lol_no     (lol_n),
    .sync_err_o (sync_err),
    .pd_sel_o   (pd_sel)
  );

  always #2500 ref_clk = ~ref_clk;  // 200 MHz

  initial begin
    #700;
    forever begin
      #((rate_sel ? 625.0 : 2500.0) / (1.0 + real'(ppm) * 1.0e-6));
      rec_clk = ~rec_clk;
    end
  end

  always @(posedge ref_clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b cyc=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_eval();
    if (mid_rate != prev_rate) begin
      lol_kn  = 1'b0;
      sync_kn = 1'b0;
    end else begin
      sync_kn  = 1'b1;
      sync_tag = (mid_rate != 0) ? "R6" : "R3";
      if (mid_ppm <= 500) begin
        exp_sync = 1'b0; exp_lol = 1'b1; lol_kn = 1'b1;
        lol_tag  = (mid_rate != 0) ? "R6" : "R2";
      end else if (mid_ppm > 1000) begin
        exp_sync = 1'b1; exp_lol = 1'b0; lol_kn = 1'b1;
        lol_tag  = (mid_rate != 0) ? "R6" : "R1";
      end else begin
        exp_sync = 1'b1;  // hysteresis band: lol holds
        lol_tag  = (mid_rate != 0) ? "R6" : "R2";
      end
    end
    evaluated = 1'b1;
  endtask

  always @(negedge ref_clk) begin
    if (rst_n) begin
      int ph;
      ph = cyc % W;
      if (ph == W/2) begin
        prev_rate = mid_rate;
        mid_rate  = int'(rate_sel);
        mid_ppm   = ppm;
      end
      if (ph == 0 && cyc >= 2*W) model_eval();
      if (los_guard > 0) los_guard--;
      if (ph > 4 && ph < W-2) begin
        if (lol_kn)  check(lol_n, exp_lol, lol_tag, "lol_no");
        if (sync_kn) check(sync_err, exp_sync, sync_tag, "sync_err_o");
        if (los_guard == 0) begin
          if (!los_n) check(pd_sel, 1'b1, "R5", "pd_sel_o holdover");
          else if (sync_kn) check(pd_sel, exp_sync, evaluated ? "R4" : "R7", "pd_sel_o");
        end
      end
      // R8: flags move only on edge N*W+1
      if (lol_n !== lol_prev || sync_err !== sync_prev) begin
        checks++;
        if (ph != 1) begin
          errors++;
          $display("FAIL R8 flag change phase act=%0d exp=1 cyc=%0d", ph, cyc);
        end
      end
      lol_prev  = lol_n;
      sync_prev = sync_err;
    end
  end

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge ref_clk);
  endtask

  initial begin
    repeat (4) @(negedge ref_clk);
    check(lol_n, 1'b0, "R7", "reset lol_no");
    check(sync_err, 1'b1, "R7", "reset sync_err_o");
    check(pd_sel, 1'b1, "R7", "reset pd_sel_o");
    rst_n = 1'b1;
    wait_cyc(2*W - 10);  ppm = 400;                 // window 3: in
    wait_cyc(3*W - 10);  ppm = 700;                 // window 4: band, lol holds high
    wait_cyc(4*W - 10);  ppm = 1200;                // window 5: out
    wait_cyc(5*W - 10);  ppm = 700;                 // window 6: band, lol holds low
    wait_cyc(6*W - 10);  ppm = 400;                 // window 7: in
    wait_cyc(6*W + 3000); los_n = 1'b0; los_guard = 6;
    wait_cyc(6*W + 5000); los_n = 1'b1; los_guard = 6;
    wait_cyc(7*W - 10);  ppm = 0;
    wait_cyc(7*W + 3000); los_n = 1'b0; los_guard = 6;  // holdover across windows 8 and 9
    wait_cyc(8*W - 10);  ppm = 1200;
    wait_cyc(9*W + 10);  rate_sel = 1'b1;           // R6: window 10 mixed, 11 clean
    wait_cyc(9*W + 3000); los_n = 1'b1; los_guard = 6;
    wait_cyc(11*W - 10); ppm = 700;
    wait_cyc(12*W - 10); ppm = 400;
    wait_cyc(13*W - 10); ppm = 0;
    wait_cyc(14*W + 20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge ref_clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=%0d exp<%0d cycles", cyc, 180000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule